// File: doc/BRIEF.md
# Memory Type Range Resolver

This block answers one question for a memory subsystem: what caching type applies to a physical address range from `start` up to, but not including, `end`. It holds three kinds of configuration. The first is a table of 88 type bytes that covers the first megabyte. The second is a set of base/mask variable-range entries. The third is a default-type register with two enable bits and an optional upper-memory limit register.

A query is presented with `q_valid` while `q_ready` is high. The block first decides in a single check cycle whether an early answer applies: disabled, fixed table, or variable ranges off. If none does, it walks the variable entries one per clock. Where several entries match, it merges their types by a precedence rule. A range that is only partly covered by an entry produces an error code. The result appears on `res_type` together with a one-cycle `done` pulse.

Configuration is written through a simple write port that has a kind selector and an index.

Top module: `mem_type_resolver`

## Requirements
- R1: After reset `q_ready` is 1, `done` is 0 and `res_type` is 0x00; `res_type` changes only in a cycle where `done` is high.
- R2: If the default-type register has never been written (write kind 3), or its two enable bits are both 0, a query returns 0xFF.
- R3: The query end is exclusive: every comparison against the end uses `q_end - 1`.
- R4: When the fixed table is present and `start < 0x100000`, the result is a fixed table byte selected by `start` alone. Below 0x80000 the index is `start>>16`. Below 0xC0000 it is `8 + ((start-0x80000)>>14)`. Otherwise it is `24 + ((start-0xC0000)>>12)`.
- R5: The default-type register keeps the default type in write-data bits 7:0 and the enable pair in bits 11:10. If bit 11 (variable ranges on) is 0, and neither R2 nor R4 applies, the result is the default type.
- R6: A variable entry takes part only when bit 11 of its mask is 1. Base and mask are compared with their low 12 bits forced to 0, and the entry type is base bits 7:0. An address matches when `(addr & mask) == (base & mask)`.
- R7: If an active entry matches `start` but not `end-1`, or the reverse, the scan stops at that entry with result 0xFE.
- R8: When more than one entry matches, uncacheable on either side gives uncacheable at once. Write-back together with write-through merges to write-through. Equal types stay the same. Any other pair gives uncacheable at once.
- R9: After a full scan, if the limit register is nonzero, `start >= 2^32` and `end-1 < limit`, the result is write-back, whatever the entries matched.
- R10: After a full scan with no such limit hit, the result is the merged type, or the default type if no entry matched.
- R11: A query is accepted only on a clock edge where `q_valid` and `q_ready` are both high. `done` lasts one cycle. Early results come 1 cycle after the accepting edge. An error or stop at entry i comes i+2 cycles after it. A full scan comes NUM_VAR+1 cycles after it.
- R12: Type encodings: uncacheable 0x00, write-combining 0x01, write-through 0x04, write-protect 0x05, write-back 0x06.
- R13: Write kinds: 0 writes fixed byte `wr_idx` (0..87) from bits 7:0. 1 writes variable base `wr_idx`. 2 writes variable mask `wr_idx`. 3 writes the default-type register. 4 writes the limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_kind | input | 3 | Register kind selector |
| wr_idx | input | 7 | Entry index for fixed or variable writes |
| wr_data | input | 36 | Write data |
| q_valid | input | 1 | Query request |
| q_ready | output | 1 | Block idle, query may be accepted |
| q_start | input | 36 | First address of the range |
| q_end | input | 36 | Address one past the range |
| done | output | 1 | One-cycle result strobe |
| res_type | output | 8 | Resolved type or error code |

## Verification
Results arrive at different times. A disabled, fixed or default answer comes one edge after the accepting edge. A partial-cover error or an uncacheable stop at entry i comes i+2 edges after it. A completed scan comes NUM_VAR+1 edges after it. The bench drives at falling edges and counts falling edges from acceptance until `done` is seen. It then compares that count against the latency expected for the scenario, and the returned type against its expected value. This way a result that arrives early or late fails even when its value is right.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

    localparam logic [7:0] TY_UC = 8'h00;
    localparam logic [7:0] TY_WC = 8'h01;
    localparam logic [7:0] TY_WT = 8'h04;
    localparam logic [7:0] TY_WP = 8'h05;
    localparam logic [7:0] TY_WB = 8'h06;
    localparam logic [7:0] RES_OFF   = 8'hFF;
    localparam logic [7:0] RES_SPLIT = 8'hFE;

    localparam int FIX_N     = 88;
    localparam int FIX_IDX_W = 7;

    typedef enum logic [2:0] {
        WK_FIXED = 3'd0,
        WK_VBASE = 3'd1,
        WK_VMASK = 3'd2,
        WK_DEFT  = 3'd3,
        WK_LIMIT = 3'd4
    } wr_kind_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_CHECK = 2'd1,
        S_SCAN  = 2'd2
    } scan_state_e;

    typedef struct packed {
        logic       stop;
        logic [7:0] ty;
    } merge_t;

    function automatic logic [FIX_IDX_W-1:0] fixed_index(input logic [19:0] a);
        if (a < 20'h80000)
            return FIX_IDX_W'(a[18:16]);
        else if (a < 20'hC0000)
            return FIX_IDX_W'(8) + FIX_IDX_W'(a[17:14]);
        else
            return FIX_IDX_W'(24) + FIX_IDX_W'(a[17:12]);
    endfunction

    function automatic merge_t merge_step(input logic have, input logic [7:0] acc,
                                          input logic [7:0] t);
        merge_t r;
        r.stop = 1'b0;
        r.ty   = t;
        if (have) begin
            if (acc == TY_UC || t == TY_UC) begin
                r.stop = 1'b1;
                r.ty   = TY_UC;
            end else if ((acc == TY_WB && t == TY_WT) || (acc == TY_WT && t == TY_WB)) begin
                r.ty = TY_WT;
            end else if (acc != t) begin
                r.stop = 1'b1;
                r.ty   = TY_UC;
            end else begin
                r.ty = acc;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/mtr_cfg_regs.sv
module mtr_cfg_regs
    import mtr_pkg::*;
#(
    parameter int ADDR_W  = 36,
    parameter int NUM_VAR = 8
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [2:0]                        wr_kind,
    input  logic [FIX_IDX_W-1:0]              wr_idx,
    input  logic [ADDR_W-1:0]                 wr_data,
    output logic [FIX_N-1:0][7:0]             fix_tab,
    output logic [NUM_VAR-1:0][ADDR_W-1:0]    var_base,
    output logic [NUM_VAR-1:0][ADDR_W-1:0]    var_mask,
    output logic [7:0]                        def_ty,
    output logic [1:0]                        glb_en,
    output logic [ADDR_W-1:0]                 limit,
    output logic                              loaded
);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < FIX_N; i++) fix_tab[i] <= 8'h00;
        end else if (wr_en && wr_kind == WK_FIXED && int'(wr_idx) < FIX_N) begin
            fix_tab[wr_idx] <= wr_data[7:0];
        end
    end

    for (genvar v = 0; v < NUM_VAR; v++) begin : g_var
        logic [ADDR_W-1:0] base_q, mask_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                base_q <= '0;
                mask_q <= '0;
            end else if (wr_en && int'(wr_idx) == v) begin
                if (wr_kind == WK_VBASE) base_q <= wr_data;
                if (wr_kind == WK_VMASK) mask_q <= wr_data;
            end
        end
        assign var_base[v] = base_q;
        assign var_mask[v] = mask_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            def_ty <= 8'h00;
            glb_en <= 2'b00;
            limit  <= '0;
            loaded <= 1'b0;
        end else if (wr_en) begin
            if (wr_kind == WK_DEFT) begin
                def_ty <= wr_data[7:0];
                glb_en <= wr_data[11:10];
                loaded <= 1'b1;
            end
            if (wr_kind == WK_LIMIT) limit <= wr_data;
        end
    end

endmodule

// File: rtl/mtr_fixed_pick.sv
module mtr_fixed_pick
    import mtr_pkg::*;
(
    input  logic [FIX_N-1:0][7:0] fix_tab,
    input  logic [19:0]           addr,
    output logic [7:0]            ty
);
    logic [FIX_IDX_W-1:0] idx;
    always_comb begin
        idx = fixed_index(addr);
        ty  = fix_tab[idx];
    end
endmodule

// File: rtl/mtr_scan.sv
module mtr_scan
    import mtr_pkg::*;
#(
    parameter int ADDR_W     = 36,
    parameter int NUM_VAR    = 8,
    parameter bit HAVE_FIXED = 1'b1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           q_valid,
    input  logic [ADDR_W-1:0]              q_start,
    input  logic [ADDR_W-1:0]              q_end,
    input  logic [NUM_VAR-1:0][ADDR_W-1:0] var_base,
    input  logic [NUM_VAR-1:0][ADDR_W-1:0] var_mask,
    input  logic [7:0]                     def_ty,
    input  logic [1:0]                     glb_en,
    input  logic [ADDR_W-1:0]              limit,
    input  logic                           loaded,
    input  logic [7:0]                     fixed_ty,
    output logic [19:0]                    cur_low,
    output logic                           q_ready,
    output logic                           done,
    output logic [7:0]                     res_type
);

    localparam int VIDX_W = (NUM_VAR > 1) ? $clog2(NUM_VAR) : 1;
    localparam logic [ADDR_W-1:0] KEEP   = {{(ADDR_W-12){1'b1}}, 12'h000};
    localparam logic [ADDR_W-1:0] FOUR_G = ADDR_W'(64'h1_0000_0000);
    localparam int VALID_BIT = 11;

    scan_state_e       state;
    logic [ADDR_W-1:0] st, ei;
    logic [VIDX_W-1:0] idx;
    logic              have;
    logic [7:0]        acc;

    logic [ADDR_W-1:0] m_v, b_v;
    logic              ent_on, sm, em, stop, last;
    logic [7:0]        stop_ty, fin_ty, nxt_acc;
    logic              nxt_have;
    merge_t            step;

    assign cur_low = st[19:0];
    assign q_ready = (state == S_IDLE);

    always_comb begin
        m_v      = var_mask[idx] & KEEP;
        b_v      = var_base[idx] & KEEP;
        ent_on   = var_mask[idx][VALID_BIT];
        sm       = ((st & m_v) == (b_v & m_v));
        em       = ((ei & m_v) == (b_v & m_v));
        step     = merge_step(have, acc, var_base[idx][7:0]);
        stop     = 1'b0;
        stop_ty  = TY_UC;
        nxt_have = have;
        nxt_acc  = acc;
        if (ent_on && (sm != em)) begin
            stop    = 1'b1;
            stop_ty = RES_SPLIT;
        end else if (ent_on && sm) begin
            nxt_have = 1'b1;
            nxt_acc  = step.ty;
            if (step.stop) begin
                stop    = 1'b1;
                stop_ty = TY_UC;
            end
        end
        last = (idx == VIDX_W'(NUM_VAR - 1));
        if (limit != '0 && st >= FOUR_G && ei < limit)
            fin_ty = TY_WB;
        else if (nxt_have)
            fin_ty = nxt_acc;
        else
            fin_ty = def_ty;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            st       <= '0;
            ei       <= '0;
            idx      <= '0;
            have     <= 1'b0;
            acc      <= 8'h00;
            done     <= 1'b0;
            res_type <= 8'h00;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (q_valid) begin
                        st    <= q_start;
                        ei    <= q_end - ADDR_W'(1);
                        state <= S_CHECK;
                    end
                end
                S_CHECK: begin
                    idx  <= '0;
                    have <= 1'b0;
                    acc  <= 8'h00;
                    if (!loaded || glb_en == 2'b00) begin
                        res_type <= RES_OFF;
                        done     <= 1'b1;
                        state    <= S_IDLE;
                    end else if (HAVE_FIXED && st[ADDR_W-1:20] == '0) begin
                        res_type <= fixed_ty;
                        done     <= 1'b1;
                        state    <= S_IDLE;
                    end else if (!glb_en[1]) begin
                        res_type <= def_ty;
                        done     <= 1'b1;
                        state    <= S_IDLE;
                    end else begin
                        state <= S_SCAN;
                    end
                end
                S_SCAN: begin
                    if (stop) begin
                        res_type <= stop_ty;
                        done     <= 1'b1;
                        state    <= S_IDLE;
                    end else if (last) begin
                        res_type <= fin_ty;
                        done     <= 1'b1;
                        state    <= S_IDLE;
                    end else begin
                        idx  <= idx + VIDX_W'(1);
                        have <= nxt_have;
                        acc  <= nxt_acc;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mem_type_resolver.sv
module mem_type_resolver
    import mtr_pkg::*;
#(
    parameter int ADDR_W     = 36,
    parameter int NUM_VAR    = 8,
    parameter bit HAVE_FIXED = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [2:0]           wr_kind,
    input  logic [6:0]           wr_idx,
    input  logic [ADDR_W-1:0]    wr_data,
    input  logic                 q_valid,
    output logic                 q_ready,
    input  logic [ADDR_W-1:0]    q_start,
    input  logic [ADDR_W-1:0]    q_end,
    output logic                 done,
    output logic [7:0]           res_type
);

    logic [FIX_N-1:0][7:0]          fix_tab;
    logic [NUM_VAR-1:0][ADDR_W-1:0] var_base, var_mask;
    logic [7:0]                     def_ty, fixed_ty;
    logic [1:0]                     glb_en;
    logic [ADDR_W-1:0]              limit;
    logic                           loaded;
    logic [19:0]                    cur_low;

    mtr_cfg_regs #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR)) u_cfg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx),
        .wr_data(wr_data), .fix_tab(fix_tab), .var_base(var_base), .var_mask(var_mask),
        .def_ty(def_ty), .glb_en(glb_en), .limit(limit), .loaded(loaded)
    );

    mtr_fixed_pick u_fix (
        .fix_tab(fix_tab), .addr(cur_low), .ty(fixed_ty)
    );

    mtr_scan #(.ADDR_W(ADDR_W), .NUM_VAR(NUM_VAR), .HAVE_FIXED(HAVE_FIXED)) u_scan (
        .clk(clk), .rst(rst), .q_valid(q_valid), .q_start(q_start), .q_end(q_end),
        .var_base(var_base), .var_mask(var_mask), .def_ty(def_ty), .glb_en(glb_en),
        .limit(limit), .loaded(loaded), .fixed_ty(fixed_ty), .cur_low(cur_low),
        .q_ready(q_ready), .done(done), .res_type(res_type)
    );

endmodule

// File: rtl/mtr_chk.sv
module mtr_chk #(
    parameter int NUM_VAR = 8
) (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [2:0] wr_kind,
    input logic       q_valid,
    input logic       q_ready,
    input logic       done,
    input logic [7:0] res_type
);

    logic       seen_def;
    logic [7:0] lat_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_def <= 1'b0;
            lat_cnt  <= 8'd0;
        end else begin
            if (wr_en && wr_kind == 3'd3) seen_def <= 1'b1;
            if (q_valid && q_ready) lat_cnt <= 8'd0;
            else if (!q_ready)      lat_cnt <= lat_cnt + 8'd1;
        end
    end

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
    // R11
    done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> q_ready);
    // R11
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (q_valid && q_ready) |=> !q_ready);
    // R11
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (lat_cnt >= 8'd1 && lat_cnt <= 8'(NUM_VAR + 1)));
    // R2
    unloaded_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !seen_def) |-> res_type == 8'hFF);
    // R1
    hold_chk: assert property (@(posedge clk) disable iff (rst) !done |-> $stable(res_type));

endmodule

bind mem_type_resolver mtr_chk #(.NUM_VAR(NUM_VAR)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind), .q_valid(q_valid),
    .q_ready(q_ready), .done(done), .res_type(res_type)
);

// File: tb/tb_mem_type_resolver.sv
`timescale 1ns/1ps
module tb_mem_type_resolver;
    localparam int AW = 36;
    localparam int NV = 8;
    localparam int FULL = NV + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_kind = '0;
    logic [6:0]    wr_idx = '0;
    logic [AW-1:0] wr_data = '0;
    logic          q_valid = 1'b0;
    logic          q_ready;
    logic [AW-1:0] q_start = '0, q_end = '0;
    logic          done;
    logic [7:0]    res_type;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    mem_type_resolver #(.ADDR_W(AW), .NUM_VAR(NV)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx),
        .wr_data(wr_data), .q_valid(q_valid), .q_ready(q_ready), .q_start(q_start),
        .q_end(q_end), .done(done), .res_type(res_type)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int kind, input int idx, input logic [AW-1:0] data);
        wr_en = 1'b1; wr_kind = 3'(kind); wr_idx = 7'(idx); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_var(input int i, input logic [AW-1:0] base, input logic [AW-1:0] size,
                           input logic [7:0] ty, input bit on);
        wr(1, i, (base & ~36'hFFF) | AW'(ty));
        wr(2, i, (~(size - 1) & 36'hF_FFFF_F000) | (on ? 36'h800 : 36'h0));
    endtask

    task automatic query(input string tag, input logic [AW-1:0] s, input logic [AW-1:0] e,
                         input logic [7:0] exp, input int exp_lat);
        int n = 0;
        q_valid = 1'b1; q_start = s; q_end = e;
        @(negedge clk);
        q_valid = 1'b0;
        while (n < 40) begin
            @(negedge clk);
            n++;
            if (done) break;
        end
        chk({tag, " type"}, 64'(res_type), 64'(exp));
        chk({tag, " latency"}, 64'(n), 64'(exp_lat));
    endtask

    task automatic t_reset();
        chk("R1 reset ready", 64'(q_ready), 64'd1);
        chk("R1 reset done", 64'(done), 64'd0);
        chk("R1 reset type", 64'(res_type), 64'd0);
    endtask

    task automatic t_unloaded();
        query("R2 never loaded", 36'h2000_0000, 36'h2000_1000, 8'hFF, 1);
        wr(3, 0, 36'h006);
        query("R2 enables clear", 36'h2000_0000, 36'h2000_1000, 8'hFF, 1);
    endtask

    task automatic t_fixed();
        wr(0, 3, 36'h05);
        wr(0, 13, 36'h04);
        wr(0, 66, 36'h06);
        wr(3, 0, 36'hC01);
        query("R4 R13 64k region", 36'h3_0000, 36'h3_1000, 8'h05, 1);
        query("R4 16k region", 36'h9_4000, 36'h9_5000, 8'h04, 1);
        query("R4 4k region", 36'hE_A000, 36'h20_0000, 8'h06, 1);
        query("R4 unset entry", 36'h0_0000, 36'h0_1000, 8'h00, 1);
    endtask

    task automatic t_vardis();
        wr(3, 0, 36'h401);
        query("R5 var off default", 36'h2000_0000, 36'h2000_1000, 8'h01, 1);
        query("R4 fixed with var off", 36'h3_0000, 36'h3_1000, 8'h05, 1);
        wr(3, 0, 36'hC01);
    endtask

    task automatic t_single();
        query("R10 no match default", 36'h2000_0000, 36'h2000_1000, 8'h01, FULL);
        set_var(2, 36'h2000_0000, 36'h1000_0000, 8'h06, 1'b1);
        query("R6 single match", 36'h2000_0000, 36'h2000_1000, 8'h06, FULL);
        set_var(2, 36'h2000_0000, 36'h1000_0000, 8'h06, 1'b0);
        query("R6 valid bit clear", 36'h2000_0000, 36'h2000_1000, 8'h01, FULL);
        wr(1, 2, 36'h2000_0F06);
        wr(2, 2, 36'hF_F000_0FFF);
        query("R6 low bits ignored", 36'h2000_0000, 36'h2000_1000, 8'h06, FULL);
    endtask

    task automatic t_split();
        query("R7 partial cover", 36'h2FFF_F000, 36'h3000_1000, 8'hFE, 4);
        query("R3 end exclusive inside", 36'h2FFF_F000, 36'h3000_0000, 8'h06, FULL);
        query("R3 end one past", 36'h2FFF_F000, 36'h3000_0001, 8'hFE, 4);
    endtask

    task automatic t_merge();
        set_var(5, 36'h2000_0000, 36'h0100_0000, 8'h04, 1'b1);
        query("R8 R12 wb+wt", 36'h2000_0000, 36'h2000_1000, 8'h04, FULL);
        set_var(5, 36'h2000_0000, 36'h0100_0000, 8'h00, 1'b1);
        query("R8 uc stops", 36'h2000_0000, 36'h2000_1000, 8'h00, 7);
        set_var(5, 36'h2000_0000, 36'h0100_0000, 8'h05, 1'b1);
        query("R8 wb+wp", 36'h2000_0000, 36'h2000_1000, 8'h00, 7);
        set_var(5, 36'h2000_0000, 36'h0100_0000, 8'h06, 1'b1);
        query("R8 equal types", 36'h2000_0000, 36'h2000_1000, 8'h06, FULL);
        set_var(5, 36'h0, 36'h1000, 8'h00, 1'b0);
        set_var(2, 36'h0, 36'h1000, 8'h00, 1'b0);
    endtask

    task automatic t_limit();
        wr(4, 0, 36'h2_0000_0000);
        query("R9 above 4G below limit", 36'h1_0000_0000, 36'h1_0000_1000, 8'h06, FULL);
        query("R9 at limit", 36'h2_0000_0000, 36'h2_0000_1000, 8'h01, FULL);
        query("R9 below 4G", 36'h8000_0000, 36'h8000_1000, 8'h01, FULL);
        set_var(1, 36'h1_0000_0000, 36'h1000_0000, 8'h04, 1'b1);
        query("R9 overrides match", 36'h1_0000_0000, 36'h1_0000_1000, 8'h06, FULL);
        wr(4, 0, 36'h0);
        query("R10 merged without limit", 36'h1_0000_0000, 36'h1_0000_1000, 8'h04, FULL);
    endtask

    task automatic t_busy();
        int n = 0;
        int pulses = 0;
        q_valid = 1'b1; q_start = 36'h1_0000_0000; q_end = 36'h1_0000_1000;
        @(negedge clk);
        q_start = 36'h3_0000; q_end = 36'h3_1000;
        chk("R11 busy after accept", 64'(q_ready), 64'd0);
        while (n < 20) begin
            @(negedge clk);
            n++;
            if (done) begin
                pulses++;
                if (pulses == 1) begin
                    chk("R11 busy query ignored", 64'(res_type), 64'h04);
                    chk("R11 busy latency", 64'(n), 64'(FULL));
                end
                q_valid = 1'b0;
            end
        end
        q_valid = 1'b0;
        chk("R11 one pulse only", 64'(pulses), 64'd1);
        chk("R1 result held", 64'(res_type), 64'h04);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL R11 watchdog actual=hung expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_unloaded();
        t_fixed();
        t_vardis();
        t_single();
        t_split();
        t_merge();
        t_limit();
        t_busy();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule